// File: doc/BRIEF.md
# Compare-Value System Timer Channel

This block is one timer channel for a single core. A 64-bit free-running counter advances on every cycle in which a tick-enable input is high. Software can also move it to any value through a dedicated load port. A 64-bit deadline register is compared against the counter with an unsigned greater-or-equal test. When the channel is enabled and not masked, a level interrupt is driven for as long as that test holds.

Software can reach the deadline in two ways. It can read or write the absolute 64-bit value directly. It can also use a signed 32-bit view that counts down. Reading this view gives the time remaining until the deadline, which is negative once the deadline has passed. Writing it sets the deadline relative to the present counter. The deadline is always stored at full width, so a far deadline never collapses into a near one.

Status and interrupt are combinational from the registered state. Any register write, counter load or tick is therefore reflected at the outputs right after the clock edge that applies it.

Top module: `cmp_timer_chan`

## Requirements
- R1: The timer condition is `counter >= deadline`, compared unsigned over 64 bits. A counter of 0x8000_0000_0000_0000 with a deadline of 1 meets it.
- R2: Reading select 2 returns the low 32 bits of (deadline − counter), sign-extended to 64 bits. The value is negative after the deadline and keeps falling as the counter advances.
- R3: Writing select 2 with value V sets the deadline to the pre-edge counter plus sign-extended V[31:0], modulo 2^64. Writing −20 when the counter is 5 gives 2^64 − 15.
- R4: Writing select 1 stores all 64 bits. A deadline 2^31+50 ahead reads as a negative relative value, yet it does not raise the interrupt until the counter actually reaches it.
- R5: The control status bit (bit 2) reads 1 exactly when enable is 1 and the condition holds. The mask bit does not affect status.
- R6: `irq` is 1 only when enable is 1, mask is 0 and the condition holds.
- R7: A counter load past a pending deadline raises status, and raises `irq` if unmasked. A load back below the deadline before unmasking leaves `irq` at 0 after unmasking.
- R8: The interrupt is a level. Clearing enable drops it, and setting enable again re-raises it while the condition holds, any number of times.
- R9: A new deadline write, absolute or relative, fully replaces the previous one. `irq` follows only the latest value.
- R10: The counter increments by one on each cycle with `tick_en` high. A load in the same cycle takes priority over the increment.
- R11: After reset the counter and deadline are 0 and the control register reads 0x2 (enable 0, mask 1), with `irq` at 0.
- R12: The control register is at select 3: bit 0 is enable, bit 1 is mask, bit 2 is status and is read-only. Register-port writes to bit 2 or to select 0 (the counter) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| ld_en | input | 1 | Counter load strobe |
| ld_value | input | 64 | Counter load value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 counter (ignored), 1 deadline, 2 relative, 3 control |
| wr_data | input | 64 | Register write data |
| rd_sel | input | 2 | Read select, same encoding as writes |
| rd_data | output | 64 | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted deadline shows up one read later as a wrong relative value and as a misplaced interrupt edge. A comparison done at 32 bits or signed makes `irq` rise early in the far-deadline case, or stay low in the high-counter case. A wrong mask or enable path makes `irq` or status disagree with the control readback in the very cycle after the control write. Counter errors skew every later relative read, so they surface within one cycle of the first tick or load.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  parameter int CNT_W = 64;
  parameter int REL_W = 32;

  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_ABS = 2'd1;
  localparam logic [1:0] SEL_REL = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // unsigned deadline test
  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] dl);
    return cnt >= dl;
  endfunction

  // time left, truncated to the relative width
  function automatic logic [REL_W-1:0] rel_of(input logic [CNT_W-1:0] dl,
                                              input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] diff;
    diff = dl - cnt;
    return diff[REL_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] sext(input logic [REL_W-1:0] v);
    return {{(CNT_W-REL_W){v[REL_W-1]}}, v};
  endfunction

  // absolute deadline from a relative write
  function automatic logic [CNT_W-1:0] abs_from_rel(input logic [CNT_W-1:0] cnt,
                                                    input logic [REL_W-1:0] v);
    return cnt + sext(v);
  endfunction
endpackage

// File: rtl/ctr_counter.sv
module ctr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         ld_en,
  input  logic [W-1:0] ld_value,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ld_en)   cnt_q <= ld_value;
    else if (tick_en) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/ctr_deadline.sv
module ctr_deadline
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_abs,
  input  logic             wr_rel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] dl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dl_q <= '0;
    else if (wr_abs) dl_q <= wr_data;
    else if (wr_rel) dl_q <= abs_from_rel(cnt, wr_data[REL_W-1:0]);
  end
endmodule

// File: rtl/ctr_control.sv
module ctr_control (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wr_en_bit,
  input  logic wr_mask_bit,
  input  logic cond,
  output logic en_q,
  output logic mask_q,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b1;
    end else if (wr_ctl) begin
      en_q   <= wr_en_bit;
      mask_q <= wr_mask_bit;
    end
  end

  assign status = en_q & cond;
  assign irq    = status & ~mask_q;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dl_q;
  logic             ctl_en, ctl_mask;
  logic             cond_w, status_w;
  logic             wr_abs_w, wr_rel_w, wr_ctl_w;

  assign wr_abs_w = wr_en && (wr_sel == SEL_ABS);
  assign wr_rel_w = wr_en && (wr_sel == SEL_REL);
  assign wr_ctl_w = wr_en && (wr_sel == SEL_CTL);

  ctr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ld_en(ld_en), .ld_value(ld_value), .cnt_q(cnt_q)
  );

  ctr_deadline u_dl (
    .clk(clk), .rst_n(rst_n), .wr_abs(wr_abs_w), .wr_rel(wr_rel_w),
    .wr_data(wr_data), .cnt(cnt_q), .dl_q(dl_q)
  );

  assign cond_w = reached(cnt_q, dl_q);

  ctr_control u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl_w),
    .wr_en_bit(wr_data[0]), .wr_mask_bit(wr_data[1]),
    .cond(cond_w), .en_q(ctl_en), .mask_q(ctl_mask),
    .status(status_w), .irq(irq)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_CNT: rd_data = cnt_q;
      SEL_ABS: rd_data = dl_q;
      SEL_REL: rd_data = sext(rel_of(dl_q, cnt_q));
      default: rd_data = {{(CNT_W-3){1'b0}}, status_w, ctl_mask, ctl_en};
    endcase
  end
endmodule

// File: rtl/cmp_timer_chan_chk.sv
module cmp_timer_chan_chk
  import cmp_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ld_en,
  input logic [CNT_W-1:0] ld_value,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] dl_q,
  input logic             ctl_en,
  input logic             ctl_mask,
  input logic             status_w
);
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mask |-> !irq);

  p_irq_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_w);

  p_status_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w && !ctl_mask) |-> irq);

  p_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld_en) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> cnt_q == $past(ld_value));

  p_rel_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_REL) |=>
      dl_q == $past(cnt_q) + {{(CNT_W-REL_W){$past(wr_data[REL_W-1])}}, $past(wr_data[REL_W-1:0])});

  p_dl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_sel == SEL_ABS || wr_sel == SEL_REL)) |=> $stable(dl_q));

  p_ctl_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTL) |=> (ctl_en == $past(wr_data[0]) && ctl_mask == $past(wr_data[1])));
endmodule

bind cmp_timer_chan cmp_timer_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_en(ld_en),
  .ld_value(ld_value), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .irq(irq), .cnt_q(cnt_q), .dl_q(dl_q), .ctl_en(ctl_en),
  .ctl_mask(ctl_mask), .status_w(status_w)
);

// File: tb/cmp_timer_chan_tb_top.sv
`timescale 1ns/100ps
module cmp_timer_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        ld_en = 1'b0;
  logic [63:0] ld_value = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model
  logic [63:0] m_cnt = '0, m_dl = '0;
  logic        m_en = 1'b0, m_mask = 1'b1;

  always #2 clk = ~clk;

  cmp_timer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_en(ld_en),
    .ld_value(ld_value), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic exp_cond();
    return !(m_cnt < m_dl);
  endfunction
  function automatic logic exp_irq();
    return m_en && !m_mask && exp_cond();
  endfunction
  function automatic logic [63:0] exp_rel();
    longint signed d;
    int signed r;
    d = longint'(m_dl) - longint'(m_cnt);
    r = int'(d);
    return 64'(longint'(r));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    rd_sel = s;
    #0.1;
    v = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [63:0] v;
    rd(2'd0, v); chk({tag, " counter"}, v, m_cnt);
    rd(2'd1, v); chk({tag, " deadline"}, v, m_dl);
    rd(2'd2, v); chk({tag, " relative"}, v, exp_rel());
    rd(2'd3, v); chk({tag, " control"}, v, {61'd0, m_en && exp_cond(), m_mask, m_en});
    chk({tag, " irq"}, {63'd0, irq}, {63'd0, exp_irq()});
  endtask

  task automatic cyc();
    @(posedge clk);
    if (wr_en) begin
      case (wr_sel)
        2'd1: m_dl = wr_data;
        2'd2: m_dl = m_cnt + {{32{wr_data[31]}}, wr_data[31:0]};
        2'd3: begin m_en = wr_data[0]; m_mask = wr_data[1]; end
        default: ;
      endcase
    end
    if (ld_en) m_cnt = ld_value;
    else if (tick_en) m_cnt = m_cnt + 64'd1;
    @(negedge clk);
    wr_en = 1'b0;
    ld_en = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [63:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
  endtask

  task automatic load(input logic [63:0] v);
    ld_en = 1'b1; ld_value = v;
    cyc();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check_all("R11");
    rd(2'd3, v); chk("R11 ctl literal", v, 64'h2);

    // R10 ticking and load priority
    tick_en = 1'b1;
    repeat (5) cyc();
    rd(2'd0, v); chk("R10 five ticks", v, 64'd5);
    load(64'd777);
    rd(2'd0, v); chk("R10 load beats tick", v, 64'd777);
    tick_en = 1'b0;
    check_all("R10");

    // R12 counter write ignored, status bit read-only
    wreg(2'd0, 64'd12345);
    rd(2'd0, v); chk("R12 counter write ignored", v, 64'd777);
    wreg(2'd3, 64'h4);
    rd(2'd3, v); chk("R12 status not writable", v, 64'h0);

    // R2 relative read negative after deadline
    load(64'd1000);
    wreg(2'd1, 64'd990);
    rd(2'd2, v); chk("R2 negative relative", v, 64'hFFFF_FFFF_FFFF_FFF6);
    tick_en = 1'b1; repeat (3) cyc(); tick_en = 1'b0;
    rd(2'd2, v); chk("R2 keeps counting down", v, 64'hFFFF_FFFF_FFFF_FFF3);
    check_all("R2");

    // R3 negative relative write with small counter
    load(64'd5);
    wreg(2'd2, 64'hFFFF_FFEC);
    rd(2'd1, v); chk("R3 wrapped deadline", v, 64'hFFFF_FFFF_FFFF_FFF1);
    check_all("R3");

    // R4 far deadline does not fire early
    wreg(2'd3, 64'h1);
    load(64'd100);
    wreg(2'd1, 64'd100 + 64'h8000_0032);
    rd(2'd2, v); chk("R4 relative wrapped", v, 64'hFFFF_FFFF_8000_0032);
    chk("R4 no early irq", {63'd0, irq}, 64'd0);
    load(64'd100 + 64'h8000_0031);
    chk("R4 one short", {63'd0, irq}, 64'd0);
    load(64'd100 + 64'h8000_0032);
    chk("R4 fires at deadline", {63'd0, irq}, 64'd1);
    check_all("R4");

    // R1 unsigned comparison
    load(64'h8000_0000_0000_0000);
    wreg(2'd1, 64'd1);
    chk("R1 unsigned high counter", {63'd0, irq}, 64'd1);
    wreg(2'd1, 64'h8000_0000_0000_0001);
    chk("R1 one below", {63'd0, irq}, 64'd0);
    check_all("R1");

    // R5 / R6 mask suppresses irq, not status
    wreg(2'd1, 64'd0);
    wreg(2'd3, 64'h3);
    rd(2'd3, v); chk("R5 status with mask", v, 64'h7);
    chk("R6 masked irq low", {63'd0, irq}, 64'd0);
    wreg(2'd3, 64'h0);
    chk("R6 disabled irq low", {63'd0, irq}, 64'd0);
    check_all("R6");

    // R7 counter moves
    load(64'd0);
    wreg(2'd1, 64'd1000);
    wreg(2'd3, 64'h3);
    load(64'd2000);
    rd(2'd3, v); chk("R7 status after forward load", v, 64'h7);
    load(64'd0);
    wreg(2'd3, 64'h1);
    chk("R7 no irq after backward move", {63'd0, irq}, 64'd0);
    load(64'd5000);
    chk("R7 irq on forward load", {63'd0, irq}, 64'd1);
    check_all("R7");

    // R8 level re-fire
    for (int i = 0; i < 3; i++) begin
      wreg(2'd3, 64'h0);
      chk("R8 dropped when disabled", {63'd0, irq}, 64'd0);
      wreg(2'd3, 64'h1);
      chk("R8 re-fires", {63'd0, irq}, 64'd1);
    end

    // R9 reprogramming replaces deadline
    load(64'd10000);
    wreg(2'd2, 64'd100);
    wreg(2'd2, 64'd10);
    load(64'd10010);
    chk("R9 later shorter wins", {63'd0, irq}, 64'd1);
    wreg(2'd2, 64'd10);
    wreg(2'd2, 64'd100);
    load(64'd10020);
    chk("R9 later longer wins", {63'd0, irq}, 64'd0);
    wreg(2'd1, 64'd5);
    chk("R9 absolute replaces", {63'd0, irq}, 64'd1);
    check_all("R9");

    // random mix: R1 R2 R3 R5 R6 R10
    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      tick_en = $urandom_range(0, 1) == 1;
      if (op < 2) begin
        ld_en = 1'b1;
        ld_value = (op == 0) ? {$urandom, $urandom} : m_dl + 64'($signed($urandom_range(0, 8)) - 4);
      end
      if (op >= 2 && op < 4) begin
        wr_en = 1'b1; wr_sel = 2'd1;
        wr_data = m_cnt + 64'($urandom_range(0, 6));
      end else if (op >= 4 && op < 6) begin
        wr_en = 1'b1; wr_sel = 2'd2;
        wr_data = {$urandom, 32'($signed($urandom_range(0, 12)) - 6)};
      end else if (op == 6) begin
        wr_en = 1'b1; wr_sel = 2'd3;
        wr_data = {$urandom, $urandom};
      end
      cyc();
      check_all("R1 R2 R3 R5 R6 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule